// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and an external asynchronous static RAM that is 16 bits wide, with a 17-bit word address. Each read or write request from the host takes a single cycle. The controller turns it into a timed sequence on the memory pins: two chip selects of opposite polarity, a write strobe, an output enable, one strobe per byte lane, an address bus, and a data bus that is split into input, output and output-enable. Every output pin comes from a register, so the strobes are glitch-free.

The host sees a `host_ready` level that is high only while the controller is idle. A request is accepted on a clock edge when `host_req` is high and the controller is idle. A two-bit mask picks the byte lanes. A read keeps the strobes active for the access count. It then captures the bus and returns the data with a one-cycle valid pulse. A write selects the device with output enable held high. It waits a turnaround count so that a previous read's drivers can release the bus. Then it drives the data, pulses the write strobe, and holds the data for one more cycle before it deselects.

The three counts are derived from parameters given in picoseconds. Each count is the ceiling of the time divided by the clock period, with a minimum of one.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and after it, until the first request: `host_ready`=1, `mem_ce_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_lb_n`=1, `mem_ub_n`=1, `mem_dq_oe`=0 and `host_rvalid`=0.
- R2: `mem_ce_n` is low exactly when `mem_ce2` is high. The device is selected only while a transaction is in progress and is deselected whenever `host_ready` is high.
- R3: A read keeps `mem_ce_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC cycles after the accepting edge, where RD_CYC = ceil(T_ACC_PS/T_CLK_PS). The bus is captured on the RD_CYC-th edge after acceptance. `host_rvalid` is high for exactly the one following cycle, together with `host_rdata`.
- R4: Mask bit 0 enables the lower lane (data bits 7..0, strobe `mem_lb_n` low). Mask bit 1 enables the upper lane (bits 15..8, `mem_ub_n` low). Any lane a read did not enable returns zero in `host_rdata`.
- R5: During a write, `mem_oe_n` stays high. The bus is not driven for the first TURN_CYC cycles, where TURN_CYC = ceil(T_OFF_PS/T_CLK_PS). `mem_we_n` is then low for WP_CYC = ceil(T_WP_PS/T_CLK_PS) cycles while `mem_dq_o` carries the write data. The data is still driven for one cycle after `mem_we_n` rises.
- R6: A write stores only the lanes whose mask bit is 1. A lane whose mask bit is 0 keeps its contents.
- R7: `mem_addr`, `mem_lb_n` and `mem_ub_n` do not change while `mem_we_n` is low or on the edge where it rises.
- R8: `host_ready` is low from the accepting edge for RD_CYC cycles for a read, or TURN_CYC+WP_CYC+1 cycles for a write. It returns high in the cycle that follows.
- R9: A request made while `host_ready` is low is ignored. The memory address does not move and no extra write takes place.
- R10: `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, sampled while ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Word address |
| host_wdata | input | 2*LANE_W | Write data |
| host_mask | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| host_ready | output | 1 | Idle, request may be accepted |
| host_rdata | output | 2*LANE_W | Read data, disabled lanes zero |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_i | input | 2*LANE_W | Data from memory |
| mem_dq_o | output | 2*LANE_W | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |

## Verification
The read-valid pulse and the acceptance of the next request can fall in the same cycle, because `host_ready` returns together with `host_rvalid`. The bench provokes this by presenting a write in the very cycle a read's data is returned. It then judges two things: that the returned data matches the lanes expected from the host's earlier writes, and that the new write still waits its full turnaround with `mem_oe_n` high before driving the bus. A second overlap is a request that arrives while a write is in progress. The bench checks that the address pins stay fixed and that the target word is unchanged when it is read back.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int AW        = 17,
  parameter int LANE_W    = 8,
  parameter int T_CLK_PS  = 10000,
  parameter int T_ACC_PS  = 55000,
  parameter int T_OFF_PS  = 20000,
  parameter int T_WP_PS   = 45000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_req,
  input  logic                  host_we,
  input  logic [AW-1:0]         host_addr,
  input  logic [2*LANE_W-1:0]   host_wdata,
  input  logic [1:0]            host_mask,
  output logic                  host_ready,
  output logic [2*LANE_W-1:0]   host_rdata,
  output logic                  host_rvalid,
  output logic                  mem_ce_n,
  output logic                  mem_ce2,
  output logic                  mem_we_n,
  output logic                  mem_oe_n,
  output logic                  mem_lb_n,
  output logic                  mem_ub_n,
  output logic [AW-1:0]         mem_addr,
  input  logic [2*LANE_W-1:0]   mem_dq_i,
  output logic [2*LANE_W-1:0]   mem_dq_o,
  output logic                  mem_dq_oe
);
  function automatic int to_cyc(input int ps);
    int c;
    c = (ps + T_CLK_PS - 1) / T_CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_CYC   = to_cyc(T_ACC_PS);
  localparam int TURN_CYC = to_cyc(T_OFF_PS);
  localparam int WP_CYC   = to_cyc(T_WP_PS);
  localparam int MAXC     = (RD_CYC > TURN_CYC) ? ((RD_CYC > WP_CYC) ? RD_CYC : WP_CYC)
                                                : ((TURN_CYC > WP_CYC) ? TURN_CYC : WP_CYC);
  localparam int CW       = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WP, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2*LANE_W-1:0] lane_keep;

  assign host_ready = (st == S_IDLE);
  assign lane_keep  = {{LANE_W{~mem_ub_n}}, {LANE_W{~mem_lb_n}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      cnt         <= '0;
      mem_ce_n    <= 1'b1;
      mem_ce2     <= 1'b0;
      mem_we_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_lb_n    <= 1'b1;
      mem_ub_n    <= 1'b1;
      mem_dq_oe   <= 1'b0;
      mem_addr    <= '0;
      mem_dq_o    <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      case (st)
        S_IDLE: if (host_req) begin
          mem_addr <= host_addr;
          mem_ce_n <= 1'b0;
          mem_ce2  <= 1'b1;
          mem_lb_n <= ~host_mask[0];
          mem_ub_n <= ~host_mask[1];
          if (host_we) begin
            mem_dq_o <= host_wdata;
            cnt      <= CW'(TURN_CYC - 1);
            st       <= S_TURN;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(RD_CYC - 1);
            st       <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          host_rdata  <= mem_dq_i & lane_keep;
          host_rvalid <= 1'b1;
          mem_oe_n    <= 1'b1;
          mem_ce_n    <= 1'b1;
          mem_ce2     <= 1'b0;
          mem_lb_n    <= 1'b1;
          mem_ub_n    <= 1'b1;
          st          <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_TURN: if (cnt == '0) begin
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          cnt       <= CW'(WP_CYC - 1);
          st        <= S_WP;
        end else cnt <= cnt - 1'b1;
        S_WP: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          st       <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: begin
          mem_dq_oe <= 1'b0;
          mem_ce_n  <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module asram_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic          mem_ce_n,
  input logic          mem_ce2,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic [AW-1:0] mem_addr,
  input logic          mem_dq_oe
);
  p_sel_pair_r2: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n != mem_ce2);
  p_idle_desel_r2: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
  p_rvalid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);
  p_strobe_ctx_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe);
  p_addr_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
  p_addr_move_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(mem_addr) |-> !host_ready);
  p_no_contend_r10: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
endmodule

bind asram_ctrl asram_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .host_ready(host_ready), .host_rvalid(host_rvalid),
  .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 5;
  localparam int WORDS = 1 << AW;
  localparam int TCLK  = 10000;
  localparam int TACC  = 25000;
  localparam int TOFF  = 15000;
  localparam int TWP   = 25000;
  localparam int RD    = (TACC + TCLK - 1) / TCLK;
  localparam int TURN  = (TOFF + TCLK - 1) / TCLK;
  localparam int WP    = (TWP + TCLK - 1) / TCLK;

  logic clk = 1'b0;
  logic rst;
  logic host_req, host_we;
  logic [AW-1:0] host_addr;
  logic [15:0] host_wdata;
  logic [1:0] host_mask;
  logic host_ready, host_rvalid;
  logic [15:0] host_rdata;
  logic mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_dq_i, mem_dq_o;

  int nchk = 0;
  int nfail = 0;
  logic [15:0] dev [WORDS];
  logic [15:0] shadow [WORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(.AW(AW), .LANE_W(8), .T_CLK_PS(TCLK), .T_ACC_PS(TACC),
               .T_OFF_PS(TOFF), .T_WP_PS(TWP)) u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
    .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_i(mem_dq_i), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe));

  wire dev_sel = (mem_ce_n === 1'b0) && (mem_ce2 === 1'b1);
  wire dev_out = dev_sel && (mem_oe_n === 1'b0) && (mem_we_n === 1'b1);
  assign mem_dq_i[7:0]  = (dev_out && !mem_lb_n) ? dev[mem_addr][7:0]  : 8'hA5;
  assign mem_dq_i[15:8] = (dev_out && !mem_ub_n) ? dev[mem_addr][15:8] : 8'h5A;

  always @(posedge mem_we_n) begin
    if (dev_sel) begin
      if (mem_lb_n === 1'b0) dev[mem_addr][7:0]  = mem_dq_o[7:0];
      if (mem_ub_n === 1'b0) dev[mem_addr][15:8] = mem_dq_o[15:8];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pins();
    return {host_ready, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, mem_lb_n, mem_ub_n};
  endfunction

  always @(negedge clk) if (!rst && mem_dq_oe === 1'b1 && mem_oe_n === 1'b0)
    chk("R10 bus driven with oe low", 0, 1);

  task automatic start(input logic we, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_mask = m;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m,
                          input bit poke);
    logic lo, lu;
    lo = ~m[0]; lu = ~m[1];
    start(1'b1, a, d, m);
    for (int k = 1; k <= TURN + WP + 1; k++) begin
      logic wl, dr;
      wl = (k > TURN) && (k <= TURN + WP);
      dr = (k > TURN);
      if (poke && k == 2) begin
        host_req = 1'b1; host_we = 1'b1; host_addr = a ^ 5'h1F; host_wdata = 16'hDEAD; host_mask = 2'b11;
      end
      if (poke && k == 3) host_req = 1'b0;
      chk("R5/R8 write strobes", {24'd0, pins()}, {24'd0, 1'b0, 1'b0, 1'b1, 1'b1, ~wl, dr, lo, lu});
      chk("R7/R9 write address", {27'd0, mem_addr}, {27'd0, a});
      if (dr) chk("R5 write data", {16'd0, mem_dq_o}, {16'd0, d});
      @(negedge clk);
    end
    chk("R2/R8 write end", {24'd0, pins()}, {24'd0, 8'b1101_1011});
    if (m[0]) shadow[a][7:0]  = d[7:0];
    if (m[1]) shadow[a][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [1:0] m);
    logic [15:0] e;
    e = shadow[a] & {{8{m[1]}}, {8{m[0]}}};
    start(1'b0, a, 16'h0, m);
    for (int k = 1; k <= RD; k++) begin
      chk("R3 read strobes", {23'd0, host_rvalid, pins()},
          {23'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ~m[0], ~m[1]});
      @(negedge clk);
    end
    chk("R3/R8 read end", {23'd0, host_rvalid, pins()}, {23'd0, 1'b1, 8'b1101_1011});
    chk("R4/R6 read data", {16'd0, host_rdata}, {16'd0, e});
  endtask

  initial begin
    rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0; host_mask = '0;
    for (int i = 0; i < WORDS; i++) begin dev[i] = 16'h0; shadow[i] = 16'h0; end
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {23'd0, host_rvalid, pins()}, {23'd0, 1'b0, 8'b1101_1011});
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {23'd0, host_rvalid, pins()}, {23'd0, 1'b0, 8'b1101_1011});
    for (int a = 0; a < WORDS; a++)
      do_write(AW'(a), {8'(a * 7 + 1), 8'(a * 13 + 2)}, 2'b11, 1'b0);
    for (int a = 0; a < WORDS; a++)
      do_read(AW'(a), 2'b11);
    for (int a = 0; a < WORDS; a++)
      do_write(AW'(a), ~{8'(a * 7 + 1), 8'(a * 13 + 2)}, 2'(a % 4), 1'b0);
    for (int a = 0; a < WORDS; a++)
      for (int m = 0; m < 4; m++) do_read(AW'(a), 2'(m));
    for (int a = 0; a < 8; a++) begin
      do_read(AW'(a), 2'b11);
      do_write(AW'(a), 16'h1234 + 16'(a), 2'(a % 4), 1'b0);
      do_read(AW'(a), 2'b11);
    end
    do_write(5'd3, 16'hBEEF, 2'b11, 1'b1);
    do_read(5'd3 ^ 5'h1F, 2'b11);
    do_read(5'd3, 2'b11);
    repeat (2) @(negedge clk);
    chk("R9 no late start", {24'd0, pins()}, {24'd0, 8'b1101_1011});
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule